// File: doc/BRIEF.md
# Telemetry PCM Frame Formatter

This block turns a stored sequence of parameter words into a serial NRZ-L telemetry stream. A frame table in local storage holds one entry per word. Each entry carries up to 16 data bits, a length of 1 to 16 bits, a bit-order flag, a parity mode and two flags that mark the end of a minor frame or of a major frame. A format start table maps each of up to 15 format numbers to the table address where that format's major frame begins. Sync patterns are ordinary entries. A pattern longer than 16 bits is stored as two consecutive entries.

While `run` is high, each single-cycle `bit_en` consumes the bit shown on `ser_out` and moves the block to the next bit. After the last word of each minor frame the block appends a 16-bit CRC word. It drives three marker outputs: one for the last bit of each word, one for the whole CRC word that closes a minor frame, and one for the CRC word that closes a major frame. The 4-bit format select is sampled only when a run starts and when a major frame ends. The tables can be written only while the block is idle.

Top module: `pcm_frame_fmt`

## Requirements
- R1: While `run` is low, or from the cycle after `run` is sampled low, `ser_out`, `word_pulse`, `minor_pulse` and `major_pulse` are all 0. Reset leaves the block idle.
- R2: A table entry is packed as follows: data in bits [15:0], length minus one in [19:16], bit-order flag in [20], parity mode in [22:21], minor-end flag in [23] and major-end flag in [24]. The word sends exactly length data bits, taken from data[length-1:0].
- R3: When bit-order flag = 0, the data bits go out from data[length-1] down to data[0]. When it is 1, they go out from data[0] up.
- R4: Parity mode 01 is odd and 10 is even. The parity bit goes out after the data bits and makes the number of ones in data plus parity odd or even. Modes 00 and 11 add no bit.
- R5: `word_pulse` is high exactly while the last bit of each word is shown, including the parity bit when there is one and the last CRC bit.
- R6: After an entry whose minor-end or major-end flag is set, a 16-bit CRC word is sent MSB first. The CRC uses polynomial 0x1021, starts at 0xFFFF, has no reflection and no final XOR, and covers every bit sent in that minor frame before the CRC word.
- R7: `minor_pulse` is high for all 16 bits of each CRC word. `major_pulse` is high for the same 16 bits only when the closing entry had its major-end flag set.
- R8: `fmt_sel` is sampled when a run starts and when a major frame's CRC word ends. The stream then continues from the format's start address, and a change at any other time has no effect until that point.
- R9: A `fmt_sel` value of `NUM_FMT` (15) or above is not a valid format. The format already in use is kept.
- R10: Writes to the frame table and to the format start table are ignored while the block is running.
- R11: Outputs change only on a cycle with `bit_en` high, apart from the start and stop of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to stream, low to stop and allow table writes |
| bit_en | input | 1 | Single-cycle enable that consumes the current bit |
| fmt_sel | input | 4 | Requested format number |
| tbl_we | input | 1 | Frame table write strobe |
| tbl_addr | input | AW | Frame table write address |
| tbl_wdata | input | 25 | Frame table entry |
| fst_we | input | 1 | Format start table write strobe |
| fst_idx | input | 4 | Format number to write |
| fst_addr | input | AW | Start address for that format |
| ser_out | output | 1 | NRZ-L serial data |
| word_pulse | output | 1 | Last bit of a word |
| minor_pulse | output | 1 | CRC word closing a minor frame |
| major_pulse | output | 1 | CRC word closing a major frame |

## Verification
The embedded assertions check several rules on every cycle: the outputs stay quiet while stopped, the outputs hold between bit enables, the major marker appears only inside the minor marker, and the minor marker covers the CRC word without a gap and then drops. Bit values, bit order, parity, CRC contents, frame wrap and format switching can only be shown by the bench. It compares whole major frames against a stream built from its own copy of the table, and it moves `fmt_sel` and the write ports in the middle of a frame.

// File: rtl/pcm_frame_fmt.sv
module pcm_frame_fmt #(
  parameter int DEPTH   = 32,
  parameter int NUM_FMT = 15,
  localparam int AW     = $clog2(DEPTH),
  localparam int EW     = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bit_en,
  input  logic [3:0]    fmt_sel,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [EW-1:0] tbl_wdata,
  input  logic          fst_we,
  input  logic [3:0]    fst_idx,
  input  logic [AW-1:0] fst_addr,
  output logic          ser_out,
  output logic          word_pulse,
  output logic          minor_pulse,
  output logic          major_pulse
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] fstart [16];

  logic [EW-1:0] ent;
  logic [AW-1:0] ptr;
  logic [4:0]    idx;
  logic          in_crc;
  logic [15:0]   crc;
  logic [3:0]    fmt;
  logic          active;

  wire [15:0] dat   = ent[15:0];
  wire [4:0]  len   = {1'b0, ent[19:16]} + 5'd1;
  wire        lsbf  = ent[20];
  wire [1:0]  pm    = ent[22:21];
  wire        mj    = ent[24];
  wire        mn    = ent[23] | ent[24];
  wire        par_on = (pm == 2'b01) || (pm == 2'b10);

  wire [15:0] mask  = ~(16'hFFFF << len);
  wire [15:0] mdat  = dat & mask;
  wire        pbit  = (pm == 2'b01) ? ~^mdat : ^mdat;

  wire [4:0]  wlen  = in_crc ? 5'd16 : len + {4'd0, par_on};
  wire        last  = (idx == wlen - 5'd1);
  wire [4:0]  pos   = lsbf ? idx : len - 5'd1 - idx;

  logic dbit;
  always_comb begin
    if (in_crc)          dbit = crc[4'd15 - idx[3:0]];
    else if (idx == len) dbit = pbit;
    else                 dbit = dat[pos[3:0]];
  end

  wire        fb      = crc[15] ^ dbit;
  wire [15:0] crc_nxt = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);

  wire [3:0]    fmt_nxt = ({28'd0, fmt_sel} < NUM_FMT) ? fmt_sel : fmt;
  wire [AW-1:0] fa      = fstart[fmt_nxt];
  wire [AW-1:0] ptr_inc = ptr + AW'(1);

  assign ser_out     = active & dbit;
  assign word_pulse  = active & last;
  assign minor_pulse = active & in_crc;
  assign major_pulse = active & in_crc & mj;

  always_ff @(posedge clk) begin
    if (tbl_we && !active) mem[tbl_addr] <= tbl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) fstart[i] <= '0;
    end else if (fst_we && !active && ({28'd0, fst_idx} < NUM_FMT)) begin
      fstart[fst_idx] <= fst_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ent    <= '0;
      ptr    <= '0;
      idx    <= '0;
      in_crc <= 1'b0;
      crc    <= 16'hFFFF;
      fmt    <= '0;
    end else if (!run) begin
      active <= 1'b0;
    end else if (!active) begin
      active <= 1'b1;
      fmt    <= fmt_nxt;
      ptr    <= fa;
      ent    <= mem[fa];
      idx    <= '0;
      in_crc <= 1'b0;
      crc    <= 16'hFFFF;
    end else if (bit_en) begin
      if (!in_crc) crc <= crc_nxt;
      if (!last) begin
        idx <= idx + 5'd1;
      end else begin
        idx <= '0;
        if (in_crc) begin
          in_crc <= 1'b0;
          crc    <= 16'hFFFF;
          if (mj) begin
            fmt <= fmt_nxt;
            ptr <= fa;
            ent <= mem[fa];
          end else begin
            ptr <= ptr_inc;
            ent <= mem[ptr_inc];
          end
        end else if (mn) begin
          in_crc <= 1'b1;
        end else begin
          ptr <= ptr_inc;
          ent <= mem[ptr_inc];
        end
      end
    end
  end

  // R1: stopped block is silent
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(ser_out | word_pulse | minor_pulse | major_pulse));

  // R11: outputs hold between bit enables
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !bit_en |=>
      $stable({ser_out, word_pulse, minor_pulse, major_pulse}));

  // R7: major marker only inside minor marker
  a_r7_major_in_minor: assert property (@(posedge clk) disable iff (!rst_n)
    major_pulse |-> minor_pulse);

  // R7: CRC word marker has no gap
  a_r7_minor_span: assert property (@(posedge clk) disable iff (!rst_n)
    minor_pulse && bit_en && !word_pulse && run |=> minor_pulse);

  // R6: a data word always follows the CRC word
  a_r6_crc_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    minor_pulse && word_pulse && bit_en && run |=> !minor_pulse);

endmodule

// File: tb/test_pcm_frame_fmt.sv
module test_pcm_frame_fmt;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  function automatic logic [24:0] pk(input logic [15:0] d, input int len,
                                     input bit lsb, input int pm, input bit mn, input bit mj);
    pk = {mj, mn, 2'(pm), lsb, 4'(len - 1), d};
  endfunction

  localparam logic [24:0] TBL [8] = '{
    pk(16'hFE6B, 16, 0, 0, 0, 0),
    pk(16'h0028,  8, 0, 0, 0, 0),
    pk(16'h0ABC, 12, 1, 1, 0, 0),
    pk(16'h0155, 10, 0, 2, 1, 0),
    pk(16'h0009,  4, 1, 0, 0, 0),
    pk(16'h1234, 16, 0, 1, 0, 1),
    pk(16'h0001,  1, 0, 2, 0, 0),
    pk(16'h005A,  7, 0, 0, 0, 1)
  };

  logic clk = 0, rst_n = 0, run = 0, bit_en = 0;
  logic [3:0] fmt_sel = 0;
  logic tbl_we = 0, fst_we = 0;
  logic [AW-1:0] tbl_addr = 0, fst_addr = 0;
  logic [24:0] tbl_wdata = 0;
  logic [3:0] fst_idx = 0;
  logic ser_out, word_pulse, minor_pulse, major_pulse;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] expq [$];

  always #10 clk = ~clk;

  pcm_frame_fmt #(.DEPTH(DEPTH)) i_pcm_frame_fmt (
    .clk, .rst_n, .run, .bit_en, .fmt_sel, .tbl_we, .tbl_addr, .tbl_wdata,
    .fst_we, .fst_idx, .fst_addr, .ser_out, .word_pulse, .minor_pulse, .major_pulse);

  wire [3:0] outs = {ser_out, word_pulse, minor_pulse, major_pulse};

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b expected %b (data,word,minor,major)", tag, got, exp);
    end
  endtask

  task automatic build(input int start);
    logic [15:0] c = 16'hFFFF;
    int p = start;
    forever begin
      logic [24:0] e = TBL[p];
      int len = int'(e[19:16]) + 1;
      int pm = int'(e[22:21]);
      int tot = len + ((pm == 1 || pm == 2) ? 1 : 0);
      int ones = 0;
      for (int i = 0; i < tot; i++) begin
        logic b;
        if (i == len) b = (pm == 1) ? ~ones[0] : ones[0];
        else begin
          b = e[20] ? e[i] : e[len - 1 - i];
          ones += int'(b);
        end
        expq.push_back({b, i == tot - 1, 2'b00});
        c = (c[15] ^ b) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
      end
      if (e[23] || e[24]) begin
        for (int i = 0; i < 16; i++)
          expq.push_back({c[15 - i], i == 15, 1'b1, e[24]});
        c = 16'hFFFF;
        if (e[24]) break;
      end
      p++;
    end
  endtask

  task automatic check_bits(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, outs, expq.pop_front());
      bit_en = 1;
      @(negedge clk);
      bit_en = 0;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] hold;
    repeat (3) @(negedge clk);
    chk("R1 reset", outs, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", outs, 4'b0000);

    for (int i = 0; i < 8; i++) begin
      tbl_we = 1; tbl_addr = AW'(i); tbl_wdata = TBL[i];
      @(negedge clk);
    end
    tbl_we = 0;
    fst_we = 1; fst_idx = 0; fst_addr = 0; @(negedge clk);
    fst_idx = 1; fst_addr = 6; @(negedge clk);
    fst_we = 0;

    // R2 R3 R4 R5 R6 R7: two major frames of format 0
    fmt_sel = 0; run = 1;
    build(0); build(0);
    check_bits(101, "R2 R3 R4 R5 R6 R7 frame0");
    // R8: change mid frame applies only after major end
    check_bits(10, "R8 before switch");
    fmt_sel = 1;
    check_bits(91, "R8 old format continues");
    build(6);
    check_bits(25, "R8 new format");
    // R9: invalid select keeps format
    fmt_sel = 15;
    build(6);
    check_bits(25, "R9 invalid select");
    // R10: writes while running ignored
    tbl_we = 1; tbl_addr = 6; tbl_wdata = pk(16'h0000, 1, 0, 1, 0, 0);
    fst_we = 1; fst_idx = 1; fst_addr = 0;
    @(negedge clk);
    tbl_we = 0; fst_we = 0;
    build(6); build(6);
    check_bits(50, "R10 writes ignored");
    // R11: hold without bit_en
    build(6);
    @(negedge clk);
    hold = outs;
    repeat (4) @(negedge clk);
    chk("R11 hold", outs, hold);
    check_bits(25, "R11 after hold");
    // R1: stop
    run = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 stopped", outs, 4'b0000);
    bit_en = 1; @(negedge clk); bit_en = 0;
    chk("R1 stopped bit_en", outs, 4'b0000);
    // R8: start samples select; R10 table entry 6 still original
    fmt_sel = 1; run = 1;
    build(6);
    check_bits(25, "R8 start sample R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule